// File: doc/BRIEF.md
# Write Burst Disconnect Decision Unit

This unit sits beside the target-side write path of a bus bridge and decides, one data phase at a time, whether the phase being accepted must be the final one of the burst. Each time the data-phase strobe is high it looks at five inputs: the kind of write, the DWORD address of that phase, the programmed cache line size, a line-disconnect enable bit and the number of free DWORD slots in the posted write buffer. One clock later it reports a registered "last phase" flag. The bus interface then ends the burst with a target disconnect on that phase.

The stopping rule depends on the kind of write. A delayed write always stops after a single transfer. A posted memory write runs up to the next 4 KB page, or up to the next cache line when the enable bit is set. A memory write and invalidate runs to the page, but stops at a line boundary when the buffer can no longer hold a whole further line. Either posted kind also stops when the phase takes the last free buffer slot. A separate registered flag reports that the buffer has no free slot, so posting must stop.

Top module: `wr_burst_disconnect`

## Requirements
- R1: Write kind encoding is 2'b00 delayed write, 2'b01 posted memory write, 2'b10 memory write and invalidate, 2'b11 reserved. A strobed phase of kind 2'b00 or 2'b11 always sets `last_phase`.
- R2: For a posted memory write with `line_disc_en` = 0, `last_phase` is set exactly when `dw_addr`+1 has its low 10 bits zero (4 KB boundary). This holds unless R7 applies.
- R3: For a posted memory write with `line_disc_en` = 1 and a valid line size, `last_phase` is set exactly when `dw_addr`+1 is a multiple of `line_size`. This holds unless R7 applies.
- R4: Only line sizes of 1, 2, 4, 8 and 16 DWORDs are valid. With any other value, both posted kinds follow the 4 KB rule, whatever the state of `line_disc_en`.
- R5: A memory write and invalidate with enough buffer room stops only at the 4 KB boundary. `line_disc_en` has no effect on this kind.
- R6: A memory write and invalidate with a valid line size also stops when `dw_addr`+1 is a multiple of `line_size` and `fifo_free` <= `line_size`. In that case the room left after the phase is less than one line.
- R7: For either posted kind, a phase strobed while `fifo_free` <= 1 sets `last_phase`, because that phase fills the buffer.
- R8: `last_phase` is registered. It shows the decision one cycle after the strobe and is low in any cycle that follows a cycle with no strobe.
- R9: `post_full` is high in the cycle after `fifo_free` was sampled as 0, and low otherwise.
- R10: During and right after synchronous reset, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_vld | input | 1 | A write data phase is accepted this cycle |
| wr_kind | input | 2 | Write kind of the current burst |
| dw_addr | input | AW | DWORD address of the accepted phase |
| line_size | input | CLS_W | Programmed cache line size in DWORDs |
| line_disc_en | input | 1 | Posted memory writes stop at line boundaries |
| fifo_free | input | FREE_W | Free DWORD slots in the posted write buffer before this phase |
| last_phase | output | 1 | Phase strobed in the previous cycle must be the last |
| post_full | output | 1 | Posted write buffer had no free slot last cycle |

## Verification
A wrong line-size decode shows up as a `last_phase` pulse that comes one or more DWORDs too early or too late inside a burst. A broken address increment moves every stop point by one phase. Both errors appear on the very next strobe that reaches a boundary. Because every decision is registered, a corrupted kind or room comparison is visible at the port exactly one cycle after the affected strobe and never later. The bench therefore samples that cycle for page, line, fill and delayed cases, plus one idle cycle after a phase.

// File: rtl/wr_disc_pkg.sv
package wr_disc_pkg;
  typedef enum logic [1:0] {
    WK_DELAYED = 2'b00,
    WK_POSTED  = 2'b01,
    WK_MWI     = 2'b10,
    WK_RSVD    = 2'b11
  } wr_kind_e;
endpackage

// File: rtl/wr_line_decode.sv
module wr_line_decode #(
  parameter int CLS_W        = 8,
  parameter int LINE_LOG_MAX = 4
) (
  input  logic [CLS_W-1:0]        line_size,
  output logic                    line_ok,
  output logic [LINE_LOG_MAX-1:0] line_mask
);
  localparam int NSIZES = LINE_LOG_MAX + 1;

  logic [NSIZES-1:0] size_hit;

  genvar k;
  generate
    for (k = 0; k < NSIZES; k++) begin : g_size
      assign size_hit[k] = (line_size == CLS_W'(1 << k));
    end
  endgenerate

  always_comb begin
    line_mask = '0;
    for (int j = 0; j < NSIZES; j++) begin
      if (size_hit[j]) line_mask = line_mask | LINE_LOG_MAX'((1 << j) - 1);
    end
  end

  assign line_ok = |size_hit;
endmodule

// File: rtl/wr_boundary_detect.sv
module wr_boundary_detect #(
  parameter int AW           = 30,
  parameter int PAGE_BITS    = 10,
  parameter int LINE_LOG_MAX = 4
) (
  input  logic [AW-1:0]           dw_addr,
  input  logic [LINE_LOG_MAX-1:0] line_mask,
  output logic                    at_page,
  output logic                    at_line
);
  logic [AW-1:0] next_addr;

  assign next_addr = dw_addr + AW'(1);
  assign at_page   = (next_addr[PAGE_BITS-1:0] == '0);
  assign at_line   = ((next_addr[LINE_LOG_MAX-1:0] & line_mask) == '0);
endmodule

// File: rtl/wr_burst_disconnect.sv
module wr_burst_disconnect
  import wr_disc_pkg::*;
#(
  parameter int AW           = 30,
  parameter int CLS_W        = 8,
  parameter int FREE_W       = 8,
  parameter int PAGE_BITS    = 10,
  parameter int LINE_LOG_MAX = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phase_vld,
  input  logic [1:0]        wr_kind,
  input  logic [AW-1:0]     dw_addr,
  input  logic [CLS_W-1:0]  line_size,
  input  logic              line_disc_en,
  input  logic [FREE_W-1:0] fifo_free,
  output logic              last_phase,
  output logic              post_full
);
  localparam int CMPW = (FREE_W > CLS_W) ? FREE_W : CLS_W;

  logic                    line_ok;
  logic [LINE_LOG_MAX-1:0] line_mask;
  logic                    at_page;
  logic                    at_line;
  logic                    fills_buf;
  logic                    short_room;
  logic                    stop_now;
  wr_kind_e                kind;

  assign kind = wr_kind_e'(wr_kind);

  wr_line_decode #(.CLS_W(CLS_W), .LINE_LOG_MAX(LINE_LOG_MAX)) u_line (
    .line_size (line_size),
    .line_ok   (line_ok),
    .line_mask (line_mask)
  );

  wr_boundary_detect #(.AW(AW), .PAGE_BITS(PAGE_BITS), .LINE_LOG_MAX(LINE_LOG_MAX)) u_bnd (
    .dw_addr   (dw_addr),
    .line_mask (line_mask),
    .at_page   (at_page),
    .at_line   (at_line)
  );

  assign fills_buf  = (fifo_free <= FREE_W'(1));
  assign short_room = (CMPW'(fifo_free) <= CMPW'(line_size));

  always_comb begin
    unique case (kind)
      WK_POSTED: stop_now = fills_buf || at_page ||
                            (line_disc_en && line_ok && at_line);
      WK_MWI:    stop_now = fills_buf || at_page ||
                            (line_ok && at_line && short_room);
      default:   stop_now = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_phase <= 1'b0;
      post_full  <= 1'b0;
    end else begin
      last_phase <= phase_vld && stop_now;
      post_full  <= (fifo_free == '0);
    end
  end

  assert_delayed_one_R1: assert property (@(posedge clk) disable iff (rst)
    (phase_vld && (wr_kind == 2'b00 || wr_kind == 2'b11)) |=> last_phase);

  assert_page_stop_R2: assert property (@(posedge clk) disable iff (rst)
    (phase_vld && wr_kind == 2'b01 && (dw_addr[PAGE_BITS-1:0] == '1)) |=> last_phase);

  assert_fill_stop_R7: assert property (@(posedge clk) disable iff (rst)
    (phase_vld && wr_kind[1] != wr_kind[0] && fifo_free <= FREE_W'(1)) |=> last_phase);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !phase_vld |=> !last_phase);

  assert_full_flag_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (post_full == ($past(fifo_free) == '0)));
endmodule

// File: tb/wr_burst_disconnect_tb.sv
module wr_burst_disconnect_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        phase_vld;
  logic [1:0]  wr_kind;
  logic [29:0] dw_addr;
  logic [7:0]  line_size;
  logic        line_disc_en;
  logic [7:0]  fifo_free;
  logic        last_phase;
  logic        post_full;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  wr_burst_disconnect u_dut (
    .clk(clk), .rst(rst), .phase_vld(phase_vld), .wr_kind(wr_kind),
    .dw_addr(dw_addr), .line_size(line_size), .line_disc_en(line_disc_en),
    .fifo_free(fifo_free), .last_phase(last_phase), .post_full(post_full)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic phase(input string req, input logic [1:0] k, input logic [29:0] a,
                       input logic [7:0] cls, input logic en, input logic [7:0] fr,
                       input logic exp);
    @(negedge clk);
    phase_vld = 1'b1; wr_kind = k; dw_addr = a;
    line_size = cls; line_disc_en = en; fifo_free = fr;
    @(negedge clk);
    phase_vld = 1'b0; fifo_free = 8'd100;
    check(req, last_phase, exp);
  endtask

  task automatic t_reset;
    rst = 1'b1; phase_vld = 1'b0; wr_kind = 2'b00; dw_addr = '0;
    line_size = 8'd8; line_disc_en = 1'b0; fifo_free = 8'd0;
    repeat (3) @(negedge clk);
    check("R10 last", last_phase, 1'b0);
    check("R10 full", post_full, 1'b0);
    fifo_free = 8'd100;
    rst = 1'b0;
  endtask

  task automatic t_delayed;
    phase("R1 delayed mid", 2'b00, 30'h123, 8'd8, 1'b0, 8'd100, 1'b1);
    phase("R1 reserved", 2'b11, 30'h004, 8'd8, 1'b1, 8'd100, 1'b1);
  endtask

  task automatic t_posted;
    phase("R2 page edge", 2'b01, 30'h3FF, 8'd8, 1'b0, 8'd100, 1'b1);
    phase("R2 before page", 2'b01, 30'h3FE, 8'd8, 1'b0, 8'd100, 1'b0);
    phase("R2 line ignored", 2'b01, 30'h007, 8'd8, 1'b0, 8'd100, 1'b0);
    phase("R3 line 8 edge", 2'b01, 30'h007, 8'd8, 1'b1, 8'd100, 1'b1);
    phase("R3 line 8 mid", 2'b01, 30'h005, 8'd8, 1'b1, 8'd100, 1'b0);
    phase("R3 line 16 edge", 2'b01, 30'h02F, 8'd16, 1'b1, 8'd100, 1'b1);
    phase("R3 line 16 mid", 2'b01, 30'h027, 8'd16, 1'b1, 8'd100, 1'b0);
    phase("R3 line 1", 2'b01, 30'h012, 8'd1, 1'b1, 8'd100, 1'b1);
  endtask

  task automatic t_badline;
    phase("R4 size 3", 2'b01, 30'h002, 8'd3, 1'b1, 8'd100, 1'b0);
    phase("R4 size 32", 2'b01, 30'h01F, 8'd32, 1'b1, 8'd100, 1'b0);
    phase("R4 size 0 page", 2'b01, 30'h7FF, 8'd0, 1'b1, 8'd100, 1'b1);
    phase("R4 mwi size 6", 2'b10, 30'h005, 8'd6, 1'b0, 8'd2, 1'b0);
  endtask

  task automatic t_mwi;
    phase("R5 room mid line", 2'b10, 30'h007, 8'd8, 1'b0, 8'd100, 1'b0);
    phase("R5 enable no effect", 2'b10, 30'h007, 8'd8, 1'b1, 8'd100, 1'b0);
    phase("R5 page", 2'b10, 30'hBFF, 8'd8, 1'b0, 8'd100, 1'b1);
    phase("R6 short room", 2'b10, 30'h007, 8'd8, 1'b0, 8'd8, 1'b1);
    phase("R6 room just ok", 2'b10, 30'h007, 8'd8, 1'b0, 8'd9, 1'b0);
    phase("R6 not at line", 2'b10, 30'h006, 8'd8, 1'b0, 8'd8, 1'b0);
  endtask

  task automatic t_fill;
    phase("R7 posted last slot", 2'b01, 30'h003, 8'd8, 1'b0, 8'd1, 1'b1);
    phase("R7 posted two slots", 2'b01, 30'h003, 8'd8, 1'b0, 8'd2, 1'b0);
    phase("R7 mwi last slot", 2'b10, 30'h003, 8'd16, 1'b0, 8'd1, 1'b1);
  endtask

  task automatic t_timing;
    phase("R8 strobe", 2'b00, 30'h0, 8'd8, 1'b0, 8'd100, 1'b1);
    @(negedge clk);
    check("R8 idle after", last_phase, 1'b0);
  endtask

  task automatic t_full;
    @(negedge clk); fifo_free = 8'd0;
    @(negedge clk); check("R9 empty space", post_full, 1'b1);
    fifo_free = 8'd5;
    @(negedge clk); check("R9 space back", post_full, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_delayed();
    t_posted();
    t_badline();
    t_mwi();
    t_fill();
    t_timing();
    t_full();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule